// File: doc/BRIEF.md
# Translation Fault Interrupt Controller

This block sits beside an address translation unit and turns the fault strobes it produces into one level-sensitive interrupt. Two kinds of fault arrive: table-walk faults, raised when the first-level or the second-level table entry met during a walk is invalid, and permission faults, raised separately for each bus master when a page's access rights forbid the request. Every fault sets a sticky bit in a status register. Software selects which bits may interrupt through an enable register and acknowledges faults by writing ones to a clear register.

For diagnosis the block keeps, for each master, the address and the table entry of the permission fault, and for each walk level the address and the one-hot set of masters involved. A capture register loads only while its status bit is clear (or is being cleared in the same cycle), so software always sees the first fault of a burst. Fault inputs are single-cycle strobes that are always accepted: there is no back-pressure, and any number of strobes may be high in one cycle. The register port is a plain 32-bit write strobe plus a combinational read address.

Top module: `iommu_fault_irq`

## Requirements
- R1: After reset the status, enable and every capture register read zero and `irq` is low.
- R2: A permission fault strobe for master i sets status bit i (i below NUM_MASTERS); a first-level walk fault sets bit 16 and a second-level walk fault sets bit 17; the status register is at offset 0x108 and its other bits read zero.
- R3: Writing a value to the clear register at 0x104 clears every status bit whose mask bit is one and leaves the others unchanged; status bits otherwise stay set.
- R4: When a fault strobe and a clear of the same status bit meet in one cycle, the bit ends up set.
- R5: The enable register at 0x100 is read/write; only bits 17:16 and the master bits store a value, other bits read zero.
- R6: `irq` is high exactly when some status bit and its enable bit are both one, following register changes with no added cycle.
- R7: A permission fault by master i stores its address, readable at 0x110 + 4*i, and its offending entry, readable at 0x150 + 4*i.
- R8: A first-level walk fault stores its address at 0x130 and its one-hot master set at 0x180; a second-level fault uses 0x134 and 0x184.
- R9: A capture register loads only when its status bit is clear or is being cleared in that cycle; later faults while the bit is set leave it unchanged.
- R10: Writes to the status and capture registers are ignored; the clear register and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_fault | input | NUM_MASTERS | Per-master permission fault strobe |
| perm_addr | input | NUM_MASTERS*ADDR_W | Faulting address, one field per master |
| perm_entry | input | NUM_MASTERS*ENTRY_W | Offending table entry, one field per master |
| l1_fault | input | 1 | First-level walk fault strobe |
| l1_addr | input | ADDR_W | First-level faulting address |
| l1_master | input | NUM_MASTERS | One-hot master set of the first-level fault |
| l2_fault | input | 1 | Second-level walk fault strobe |
| l2_addr | input | ADDR_W | Second-level faulting address |
| l2_master | input | NUM_MASTERS | One-hot master set of the second-level fault |
| reg_wr_en | input | 1 | Register write strobe |
| reg_waddr | input | 12 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 12 | Register read byte offset |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check that status bits stay set unless cleared, that a clear removes a bit only when no fault hits it in the same cycle, that a fault always leaves its bit set, that the interrupt does not move while status and enable hold, and that each capture register stays frozen while its bit is pending. Only the bench scenarios show the register decode: which offset returns which capture, that enable masks unused bits, that writes to read-only offsets do nothing, and that a clear together with a new walk fault reloads the capture with the new address.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int REG_W = 32;
  localparam int OFS_W = 12;

  // Register offsets; software decodes these, so they are fixed.
  localparam logic [OFS_W-1:0] OFS_ENABLE  = 12'h100;
  localparam logic [OFS_W-1:0] OFS_CLEAR   = 12'h104;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 12'h108;
  localparam logic [OFS_W-1:0] OFS_PADDR   = 12'h110;
  localparam logic [OFS_W-1:0] OFS_L1_ADDR = 12'h130;
  localparam logic [OFS_W-1:0] OFS_L2_ADDR = 12'h134;
  localparam logic [OFS_W-1:0] OFS_PENTRY  = 12'h150;
  localparam logic [OFS_W-1:0] OFS_L1_WHO  = 12'h180;
  localparam logic [OFS_W-1:0] OFS_L2_WHO  = 12'h184;

  localparam int BIT_L1 = 16;
  localparam int BIT_L2 = 17;

  // Bits of status/enable that hold state for a given master count.
  function automatic logic [REG_W-1:0] live_mask(input int nm);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < nm; i++) m[i] = 1'b1;
    m[BIT_L1] = 1'b1;
    m[BIT_L2] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fic_capture.sv
module fic_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/fic_status.sv
module fic_status
  import fic_pkg::*;
#(
  parameter int NUM_MASTERS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  input  logic             en_wr,
  input  logic [REG_W-1:0] en_wdata,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] enable_q,
  output logic [REG_W-1:0] load_ok,
  output logic             irq
);
  localparam logic [REG_W-1:0] LIVE = live_mask(NUM_MASTERS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      // set applied after clear: a same-cycle event wins
      status_q <= ((status_q & ~clr_vec) | set_vec) & LIVE;
      if (en_wr) enable_q <= en_wdata & LIVE;
    end
  end

  // capture may load when the bit is free now or being freed this cycle
  assign load_ok = ~status_q | clr_vec;
  assign irq     = |(status_q & enable_q);
endmodule

// File: rtl/fic_readmux.sv
module fic_readmux
  import fic_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_W     = 32
) (
  input  logic [OFS_W-1:0]               raddr,
  input  logic [REG_W-1:0]               status,
  input  logic [REG_W-1:0]               enable,
  input  logic [NUM_MASTERS*ADDR_W-1:0]  pa_q,
  input  logic [NUM_MASTERS*ENTRY_W-1:0] pd_q,
  input  logic [ADDR_W-1:0]              l1a_q,
  input  logic [ADDR_W-1:0]              l2a_q,
  input  logic [NUM_MASTERS-1:0]         l1w_q,
  input  logic [NUM_MASTERS-1:0]         l2w_q,
  output logic [REG_W-1:0]               rdata
);
  always_comb begin
    rdata = '0;
    case (raddr)
      OFS_ENABLE:  rdata = enable;
      OFS_STATUS:  rdata = status;
      OFS_L1_ADDR: rdata[ADDR_W-1:0] = l1a_q;
      OFS_L2_ADDR: rdata[ADDR_W-1:0] = l2a_q;
      OFS_L1_WHO:  rdata[NUM_MASTERS-1:0] = l1w_q;
      OFS_L2_WHO:  rdata[NUM_MASTERS-1:0] = l2w_q;
      default:     rdata = '0;
    endcase
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (raddr == OFS_PADDR + OFS_W'(4 * i))
        rdata[ADDR_W-1:0] = pa_q[i*ADDR_W +: ADDR_W];
      if (raddr == OFS_PENTRY + OFS_W'(4 * i))
        rdata[ENTRY_W-1:0] = pd_q[i*ENTRY_W +: ENTRY_W];
    end
  end
endmodule

// File: rtl/iommu_fault_irq.sv
module iommu_fault_irq
  import fic_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_W     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_MASTERS-1:0]         perm_fault,
  input  logic [NUM_MASTERS*ADDR_W-1:0]  perm_addr,
  input  logic [NUM_MASTERS*ENTRY_W-1:0] perm_entry,
  input  logic                           l1_fault,
  input  logic [ADDR_W-1:0]              l1_addr,
  input  logic [NUM_MASTERS-1:0]         l1_master,
  input  logic                           l2_fault,
  input  logic [ADDR_W-1:0]              l2_addr,
  input  logic [NUM_MASTERS-1:0]         l2_master,
  input  logic                           reg_wr_en,
  input  logic [11:0]                    reg_waddr,
  input  logic [31:0]                    reg_wdata,
  input  logic [11:0]                    reg_raddr,
  output logic [31:0]                    reg_rdata,
  output logic                           irq
);
  logic [REG_W-1:0] set_vec, clr_vec, status_q, enable_q, load_ok;
  logic             en_wr;
  logic [NUM_MASTERS*ADDR_W-1:0]  pa_q;
  logic [NUM_MASTERS*ENTRY_W-1:0] pd_q;
  logic [ADDR_W-1:0]              l1a_q, l2a_q;
  logic [NUM_MASTERS-1:0]         l1w_q, l2w_q;

  always_comb begin
    set_vec = '0;
    set_vec[NUM_MASTERS-1:0] = perm_fault;
    set_vec[BIT_L1] = l1_fault;
    set_vec[BIT_L2] = l2_fault;
  end

  assign clr_vec = (reg_wr_en && reg_waddr == OFS_CLEAR) ? reg_wdata : '0;
  assign en_wr   = reg_wr_en && reg_waddr == OFS_ENABLE;

  fic_status #(.NUM_MASTERS(NUM_MASTERS)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .en_wr(en_wr), .en_wdata(reg_wdata), .status_q(status_q),
    .enable_q(enable_q), .load_ok(load_ok), .irq(irq)
  );

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_perm
    fic_capture #(.W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(perm_fault[g] & load_ok[g]),
      .d(perm_addr[g*ADDR_W +: ADDR_W]), .q(pa_q[g*ADDR_W +: ADDR_W])
    );
    fic_capture #(.W(ENTRY_W)) u_entry (
      .clk(clk), .rst_n(rst_n), .load(perm_fault[g] & load_ok[g]),
      .d(perm_entry[g*ENTRY_W +: ENTRY_W]), .q(pd_q[g*ENTRY_W +: ENTRY_W])
    );
  end

  fic_capture #(.W(ADDR_W + NUM_MASTERS)) u_l1 (
    .clk(clk), .rst_n(rst_n), .load(l1_fault & load_ok[BIT_L1]),
    .d({l1_master, l1_addr}), .q({l1w_q, l1a_q})
  );
  fic_capture #(.W(ADDR_W + NUM_MASTERS)) u_l2 (
    .clk(clk), .rst_n(rst_n), .load(l2_fault & load_ok[BIT_L2]),
    .d({l2_master, l2_addr}), .q({l2w_q, l2a_q})
  );

  fic_readmux #(.NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_rd (
    .raddr(reg_raddr), .status(status_q), .enable(enable_q), .pa_q(pa_q),
    .pd_q(pd_q), .l1a_q(l1a_q), .l2a_q(l2a_q), .l1w_q(l1w_q), .l2w_q(l2w_q),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/fic_checker.sv
module fic_checker
  import fic_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_W     = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [11:0]                    waddr,
  input logic [31:0]                    wdata,
  input logic [REG_W-1:0]               set_vec,
  input logic [REG_W-1:0]               status,
  input logic [REG_W-1:0]               enable,
  input logic                           irq,
  input logic [NUM_MASTERS*ADDR_W-1:0]  pa_q,
  input logic [NUM_MASTERS*ENTRY_W-1:0] pd_q,
  input logic [ADDR_W-1:0]              l1a_q,
  input logic [ADDR_W-1:0]              l2a_q
);
  logic [REG_W-1:0] clr;
  assign clr = (wr_en && waddr == OFS_CLEAR) ? wdata : '0;

  assert_status_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(status) & ~$past(clr)) & ~status) == '0));

  assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr) & ~$past(set_vec) & status) == '0));

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_vec) & ~status) == '0));

  assert_irq_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(status) && $stable(enable)) |-> $stable(irq));

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_hold
    assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status[g]) && !$past(clr[g])) |->
        ($stable(pa_q[g*ADDR_W +: ADDR_W]) && $stable(pd_q[g*ENTRY_W +: ENTRY_W])));
  end

  assert_l1_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status[BIT_L1]) && !$past(clr[BIT_L1])) |-> $stable(l1a_q));

  assert_l2_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status[BIT_L2]) && !$past(clr[BIT_L2])) |-> $stable(l2a_q));
endmodule

bind iommu_fault_irq fic_checker #(
  .NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .waddr(reg_waddr),
  .wdata(reg_wdata), .set_vec(set_vec), .status(status_q), .enable(enable_q),
  .irq(irq), .pa_q(pa_q), .pd_q(pd_q), .l1a_q(l1a_q), .l2a_q(l2a_q)
);

// File: tb/tb_iommu_fault_irq.sv
module tb_iommu_fault_irq;
  localparam int NM = 6;
  localparam int AW = 32;
  localparam int EW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0] perm_fault = '0;
  logic [NM*AW-1:0] perm_addr = '0;
  logic [NM*EW-1:0] perm_entry = '0;
  logic l1_fault = 1'b0, l2_fault = 1'b0;
  logic [AW-1:0] l1_addr = '0, l2_addr = '0;
  logic [NM-1:0] l1_master = '0, l2_master = '0;
  logic reg_wr_en = 1'b0;
  logic [11:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic mon_go = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  iommu_fault_irq #(.NUM_MASTERS(NM), .ADDR_W(AW), .ENTRY_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .perm_fault(perm_fault), .perm_addr(perm_addr),
    .perm_entry(perm_entry), .l1_fault(l1_fault), .l1_addr(l1_addr),
    .l1_master(l1_master), .l2_fault(l2_fault), .l2_addr(l2_addr),
    .l2_master(l2_master), .reg_wr_en(reg_wr_en), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: pops the expected value and compares away from the edge
  always @(negedge clk) begin
    if (mon_go && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: offset %h got %h expected %h", t, reg_raddr, reg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    reg_raddr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    mon_go = 1'b1;
    @(posedge clk); #1;
    mon_go = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_waddr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic perm(input int g, input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    perm_fault[g] = 1'b1;
    perm_addr[g*AW +: AW] = a;
    perm_entry[g*EW +: EW] = d;
    @(posedge clk); #1;
    perm_fault = '0;
  endtask

  task automatic walk(input bit second, input logic [31:0] a, input logic [NM-1:0] who);
    @(posedge clk); #1;
    if (second) begin l2_fault = 1'b1; l2_addr = a; l2_master = who; end
    else        begin l1_fault = 1'b1; l1_addr = a; l1_master = who; end
    @(posedge clk); #1;
    l1_fault = 1'b0; l2_fault = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(12'h108, 32'h0, "R1 status");
    rd(12'h100, 32'h0, "R1 enable");
    rd(12'h110, 32'h0, "R1 capture");
    chk_irq(1'b0, "R1 irq");

    // R5: only live bits of enable store
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, 32'h0003_003F, "R5 enable mask");

    // R2, R7, R6: permission fault on master 2
    perm(2, 32'h8000_1234, 32'h0000_00A2);
    rd(12'h108, 32'h0000_0004, "R2 perm bit");
    rd(12'h118, 32'h8000_1234, "R7 perm addr");
    rd(12'h158, 32'h0000_00A2, "R7 perm entry");
    chk_irq(1'b1, "R6 irq set");

    // R9: second fault while pending keeps first capture
    perm(2, 32'h9999_0000, 32'h0000_0011);
    rd(12'h118, 32'h8000_1234, "R9 perm addr held");
    rd(12'h158, 32'h0000_00A2, "R9 perm entry held");

    // R8: walk faults
    walk(1'b0, 32'h0012_3000, 6'b001000);
    walk(1'b1, 32'h0045_6000, 6'b100000);
    rd(12'h108, 32'h0003_0004, "R2 walk bits");
    rd(12'h130, 32'h0012_3000, "R8 l1 addr");
    rd(12'h180, 32'h0000_0008, "R8 l1 master");
    rd(12'h134, 32'h0045_6000, "R8 l2 addr");
    rd(12'h184, 32'h0000_0020, "R8 l2 master");

    // R6: masking
    wr(12'h100, 32'h0);
    chk_irq(1'b0, "R6 all masked");
    wr(12'h100, 32'h0001_0000);
    chk_irq(1'b1, "R6 l1 enabled");

    // R10: read-only and unmapped
    wr(12'h108, 32'h0);
    rd(12'h108, 32'h0003_0004, "R10 status write ignored");
    wr(12'h118, 32'h0);
    rd(12'h118, 32'h8000_1234, "R10 capture write ignored");
    rd(12'h104, 32'h0, "R10 clear reads zero");
    rd(12'h1F0, 32'h0, "R10 unmapped");

    // R3: selective clear
    wr(12'h104, 32'h0000_0004);
    rd(12'h108, 32'h0003_0000, "R3 selective clear");

    // R4 + R9: clear and new l1 fault in one cycle
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_waddr = 12'h104; reg_wdata = 32'h0001_0000;
    l1_fault = 1'b1; l1_addr = 32'h00AB_C000; l1_master = 6'b000001;
    @(posedge clk); #1;
    reg_wr_en = 1'b0; l1_fault = 1'b0;
    rd(12'h108, 32'h0003_0000, "R4 event wins");
    rd(12'h130, 32'h00AB_C000, "R9 reload on clear");
    rd(12'h180, 32'h0000_0001, "R9 master reload");

    // R3: clear all
    wr(12'h104, 32'h0003_003F);
    rd(12'h108, 32'h0, "R3 clear all");
    chk_irq(1'b0, "R6 irq after clear");

    // R2, R7: two masters at once, master bits not enabled
    @(posedge clk); #1;
    perm_fault = 6'b100001;
    perm_addr[0 +: AW] = 32'h1111_0000;
    perm_addr[5*AW +: AW] = 32'h5555_0000;
    @(posedge clk); #1;
    perm_fault = '0;
    rd(12'h108, 32'h0000_0021, "R2 two masters");
    rd(12'h110, 32'h1111_0000, "R7 master0 addr");
    rd(12'h124, 32'h5555_0000, "R7 master5 addr");
    chk_irq(1'b0, "R6 masked masters");

    finish_run();
  end
endmodule